// File: doc/BRIEF.md
# Host Bus Port with Selectable Data Width

This block sits between a converter core and a microprocessor bus. The host drives active-low chip select, read and write strobes. Input data arrives on an 8-bit write path. Output data leaves on a 13-bit read path, and each bit of that path has its own output enable for the pad ring. Every write updates the configuration register, and that register cannot be read back. Every read returns the most recent conversion result, which the core delivers through a load pulse.

The strobes and write data are oversampled on the system clock. One access is counted for each period in which chip select and a strobe are low together. A strap pin is captured only while reset is asserted. It decides whether configuration data is taken at the start of a write strobe or at its end.

A width bit in the configuration register chooses how results are read. In wide mode the whole 13-bit two's-complement result comes out in one read. In narrow mode only the low eight lanes are driven. Reads then alternate between the low byte and the high byte, and the high byte carries the sign bit copied into its three top positions.

Top module: `hostbus_port`

## Requirements
- R1: The write-edge strap is captured only while rst_n is low; changing it after reset has no effect on which data a write stores.
- R2: With the strap captured low, a write stores the wr_data value present in the last sample before the write strobe is released.
- R3: With the strap captured high, a write stores the wr_data value present in the first sample after the write strobe is asserted.
- R4: Each chip-select/write assertion updates cfg_q exactly once and raises cfg_written for one cycle; a write strobe with chip select high changes nothing.
- R5: After reset cfg_q is 8'h10, whose width bit (bit 3) is 0, so the port starts in narrow mode.
- R6: bus_oe is nonzero only while cs_n and rd_n are both low; a write cycle or a read strobe without chip select enables no lane.
- R7: In narrow mode (cfg_q bit 3 = 0) a read enables exactly lanes 7..0 (bus_oe = 13'h00FF), and lanes 12..8 stay undriven.
- R8: In narrow mode the first read after a load returns result[7:0] and the next returns {3 copies of result[12], result[12:8]}, alternating after that; reads without chip select do not advance the alternation.
- R9: In wide mode (cfg_q bit 3 = 1) every read enables all 13 lanes and returns the full result.
- R10: The byte alternation returns to the low byte on a result load and while wide mode is selected.
- R11: A configuration write takes all eight bits of wr_data in a single access in either width mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the host strobes |
| rst_n | input | 1 | Synchronous active-low reset, also the power-up window for the strap |
| edge_strap | input | 1 | Write-edge strap: 0 = take data at strobe release, 1 = at strobe assertion |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wr_data | input | 8 | Write data from pad lanes 7..0 |
| bus_out | output | 13 | Read data toward the pads |
| bus_oe | output | 13 | Per-lane output enable, 1 = drive |
| result_in | input | 13 | Conversion result in two's complement |
| result_load | input | 1 | One-cycle pulse that captures result_in |
| cfg_q | output | 8 | Configuration register contents |
| cfg_written | output | 1 | One-cycle pulse on each configuration update |

## Verification
The bench uses the default parameters: a 13-bit result, an 8-bit configuration word and a two-stage sampler. At this size a strided sweep of results reaches every high-byte pattern with both sign values, in both width modes. Each write drives two different data values within one strobe, so a single write shows which edge the captured strap selected. The bench resets once with each strap value and flips the strap after each reset.

// File: rtl/hostbus_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the host bus port.
package hostbus_pkg;
    // Which write-strobe edge stores configuration data.
    typedef enum logic {
        LATCH_ON_RELEASE = 1'b0,
        LATCH_ON_ASSERT  = 1'b1
    } latch_edge_e;

    // Which half of the result the next narrow read returns.
    typedef enum logic {
        BYTE_LOW  = 1'b0,
        BYTE_HIGH = 1'b1
    } byte_phase_e;
endpackage

// File: rtl/hostbus_strobe_sampler.sv
`timescale 1ns/1ps
// Oversamples the asynchronous host strobes and write data through a
// STAGES-deep register chain, then detects start and end of the combined
// chip-select/strobe assertions. Assumes STAGES >= 1. Data and strobes travel
// through the same chain, so they stay aligned sample for sample.
module hostbus_strobe_sampler #(
    parameter int STAGES = 2,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] din,
    output logic          rd_end,
    output logic          wr_begin,
    output logic          wr_end,
    output logic [DW-1:0] data_now,
    output logic [DW-1:0] data_last
);
    localparam int W      = DW + 3;
    localparam int CS_BIT = W - 1;
    localparam int RD_BIT = W - 2;
    localparam int WR_BIT = W - 3;

    logic [W-1:0]              raw;
    logic [STAGES-1:0][W-1:0]  stage;
    logic [W-1:0]              newest;
    logic                      rd_act;
    logic                      wr_act;
    logic                      rd_act_q;
    logic                      wr_act_q;
    logic [DW-1:0]             data_q;

    assign raw = {~cs_n, ~rd_n, ~wr_n, din};

    // Shift raw pins through the sampling chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            stage[0] <= raw;
            for (int k = 1; k < STAGES; k++) begin
                stage[k] <= stage[k-1];
            end
        end
    end

    // Decode combined activity from the newest sample.
    always_comb begin
        newest   = stage[STAGES-1];
        rd_act   = newest[CS_BIT] & newest[RD_BIT];
        wr_act   = newest[CS_BIT] & newest[WR_BIT];
        data_now = newest[DW-1:0];
    end

    // Keep one sample of history for edge detection and release-edge data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            wr_act_q <= 1'b0;
            data_q   <= '0;
        end else begin
            rd_act_q <= rd_act;
            wr_act_q <= wr_act;
            data_q   <= data_now;
        end
    end

    // Produce single-cycle access events.
    always_comb begin
        rd_end    = rd_act_q & ~rd_act;
        wr_begin  = wr_act & ~wr_act_q;
        wr_end    = wr_act_q & ~wr_act;
        data_last = data_q;
    end
endmodule

// File: rtl/hostbus_cfg_port.sv
`timescale 1ns/1ps
// Captures the write-edge strap during reset and stores configuration data
// on the edge it selects. Assumes wr_begin/wr_end come from the sampler, with
// data_now aligned to the first active sample and data_last to the last one.
module hostbus_cfg_port
    import hostbus_pkg::*;
#(
    parameter int             CFG_W     = 8,
    parameter logic [CFG_W-1:0] RESET_VAL = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap,
    input  logic             wr_begin,
    input  logic             wr_end,
    input  logic [CFG_W-1:0] data_now,
    input  logic [CFG_W-1:0] data_last,
    output logic [CFG_W-1:0] cfg_q,
    output logic             cfg_written,
    output latch_edge_e      edge_sel
);
    logic             take;
    logic [CFG_W-1:0] pick;

    // Follow the strap only while reset holds; freeze it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_sel <= latch_edge_e'(strap);
        end
    end

    // Choose the event and data sample that the strap selects.
    always_comb begin
        if (edge_sel == LATCH_ON_ASSERT) begin
            take = wr_begin;
            pick = data_now;
        end else begin
            take = wr_end;
            pick = data_last;
        end
    end

    // Store configuration and flag the update for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= RESET_VAL;
            cfg_written <= 1'b0;
        end else begin
            cfg_written <= take;
            if (take) begin
                cfg_q <= pick;
            end
        end
    end
endmodule

// File: rtl/hostbus_read_port.sv
`timescale 1ns/1ps
// Holds the latest result and presents it to the pads, either whole or as
// alternating low/high bytes with the sign copied into the high byte's spare
// bits. Output enables follow the raw strobes so the bus turns around without
// sampling delay. Assumes BYTE_W < DW <= 2*BYTE_W.
module hostbus_read_port
    import hostbus_pkg::*;
#(
    parameter int DW     = 13,
    parameter int BYTE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          rd_end,
    input  logic          wide,
    input  logic [DW-1:0] result_in,
    input  logic          result_load,
    output logic [DW-1:0] bus_out,
    output logic [DW-1:0] bus_oe,
    output byte_phase_e   phase
);
    localparam int HI_W  = DW - BYTE_W;
    localparam int EXT_W = BYTE_W - HI_W;

    logic [DW-1:0]     held;
    logic              sel;
    logic [BYTE_W-1:0] hi_byte;

    // Capture each new result from the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (result_load) begin
            held <= result_in;
        end
    end

    // Track which byte the next narrow read returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= BYTE_LOW;
        end else if (result_load || wide) begin
            phase <= BYTE_LOW;
        end else if (rd_end) begin
            phase <= (phase == BYTE_LOW) ? BYTE_HIGH : BYTE_LOW;
        end
    end

    // Select the read data and the lanes to drive.
    always_comb begin
        sel     = ~cs_n & ~rd_n;
        hi_byte = {{EXT_W{held[DW-1]}}, held[DW-1:BYTE_W]};
        if (wide) begin
            bus_out = held;
        end else if (phase == BYTE_HIGH) begin
            bus_out = {{HI_W{1'b0}}, hi_byte};
        end else begin
            bus_out = {{HI_W{1'b0}}, held[BYTE_W-1:0]};
        end
        bus_oe = {{HI_W{sel & wide}}, {BYTE_W{sel}}};
    end
endmodule

// File: rtl/hostbus_port.sv
`timescale 1ns/1ps
// Host-side parallel port of the converter: oversampled strobes, a
// write-only configuration register with strap-selected latch edge, and a
// result read path of selectable width. Assumes the strobes are asynchronous
// to clk and held low for at least SYNC_STAGES+1 clock periods.
module hostbus_port
    import hostbus_pkg::*;
#(
    parameter int               DATA_W      = 13,
    parameter int               CFG_W       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter int               WIDTH_BIT   = 3,
    parameter logic [CFG_W-1:0] CFG_RESET   = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_strap,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_oe,
    input  logic [DATA_W-1:0] result_in,
    input  logic              result_load,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              cfg_written
);
    logic             rd_end;
    logic             wr_begin;
    logic             wr_end;
    logic [CFG_W-1:0] data_now;
    logic [CFG_W-1:0] data_last;
    logic             wide;
    latch_edge_e      edge_sel;
    byte_phase_e      phase_w;

    hostbus_strobe_sampler #(
        .STAGES (SYNC_STAGES),
        .DW     (CFG_W)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .din       (wr_data),
        .rd_end    (rd_end),
        .wr_begin  (wr_begin),
        .wr_end    (wr_end),
        .data_now  (data_now),
        .data_last (data_last)
    );

    hostbus_cfg_port #(
        .CFG_W     (CFG_W),
        .RESET_VAL (CFG_RESET)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap       (edge_strap),
        .wr_begin    (wr_begin),
        .wr_end      (wr_end),
        .data_now    (data_now),
        .data_last   (data_last),
        .cfg_q       (cfg_q),
        .cfg_written (cfg_written),
        .edge_sel    (edge_sel)
    );

    assign wide = cfg_q[WIDTH_BIT];

    hostbus_read_port #(
        .DW     (DATA_W),
        .BYTE_W (CFG_W)
    ) u_read (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .rd_end      (rd_end),
        .wide        (wide),
        .result_in   (result_in),
        .result_load (result_load),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .phase       (phase_w)
    );
endmodule

// File: rtl/hostbus_port_chk.sv
`timescale 1ns/1ps
// Property checker for hostbus_port, attached by bind below.
module hostbus_port_chk #(
    parameter int DATA_W = 13,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] bus_out,
    input logic [DATA_W-1:0] bus_oe,
    input logic [BYTE_W-1:0] cfg_q,
    input logic              cfg_written,
    input logic              result_load,
    input logic              edge_sel,
    input logic              hi_phase,
    input logic              wide
);
    localparam int HI_W  = DATA_W - BYTE_W;
    localparam int EXT_W = BYTE_W - HI_W;

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(edge_sel)); // R1
    AST_CFG_MOVES_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> cfg_written); // R4
    AST_SINGLE_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_written |=> !cfg_written); // R4
    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe != '0) |-> (!cs_n && !rd_n)); // R6
    AST_NARROW_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (bus_oe[DATA_W-1:BYTE_W] == '0)); // R7
    AST_HIGH_BYTE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && hi_phase && bus_oe[0]) |->
        (bus_out[BYTE_W-1:BYTE_W-EXT_W] == {EXT_W{bus_out[HI_W-1]}})); // R8
    AST_WIDE_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !cs_n && !rd_n) |-> (bus_oe == {DATA_W{1'b1}})); // R9
    AST_WIDE_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wide |=> !hi_phase); // R10
    AST_LOAD_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        result_load |=> !hi_phase); // R10
endmodule

bind hostbus_port hostbus_port_chk #(
    .DATA_W (DATA_W),
    .BYTE_W (CFG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .cfg_q       (cfg_q),
    .cfg_written (cfg_written),
    .result_load (result_load),
    .edge_sel    (edge_sel),
    .hi_phase    (phase_w),
    .wide        (wide)
);

// File: tb/hostbus_port_test.sv
`timescale 1ns/1ps
// Self-checking bench for hostbus_port with default parameters.
module hostbus_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        edge_strap = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  wr_data = '0;
    logic [12:0] bus_out;
    logic [12:0] bus_oe;
    logic [12:0] result_in = '0;
    logic        result_load = 1'b0;
    logic [7:0]  cfg_q;
    logic        cfg_written;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hostbus_port uut (
        .clk(clk), .rst_n(rst_n), .edge_strap(edge_strap),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .wr_data(wr_data),
        .bus_out(bus_out), .bus_oe(bus_oe),
        .result_in(result_in), .result_load(result_load),
        .cfg_q(cfg_q), .cfg_written(cfg_written)
    );

    always @(negedge clk) if (rst_n && cfg_written) pulses++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; edge_strap = strap;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        wait_cyc(5);
        rst_n = 1'b1;
        edge_strap = ~strap;   // later strap changes must be ignored
        wait_cyc(2);
    endtask

    // Write with data 'first' at strobe assertion and 'second' before release.
    task automatic cfg_write(input logic [7:0] first, input logic [7:0] second, input bit with_cs);
        @(negedge clk);
        wr_data = first; cs_n = ~with_cs; wr_n = 1'b0;
        wait_cyc(5);
        wr_data = second;
        wait_cyc(2);
        chk("R6 no drive during write", {19'd0, bus_oe}, 32'd0);
        wait_cyc(3);
        wr_n = 1'b1; cs_n = 1'b1;
        wait_cyc(8);
    endtask

    task automatic read_cycle(input bit with_cs, output logic [12:0] d, output logic [12:0] oe);
        @(negedge clk);
        cs_n = ~with_cs; rd_n = 1'b0;
        wait_cyc(3);
        d = bus_out; oe = bus_oe;
        rd_n = 1'b1; cs_n = 1'b1;
        wait_cyc(8);
    endtask

    task automatic load(input logic [12:0] v);
        @(negedge clk);
        result_in = v; result_load = 1'b1;
        @(negedge clk);
        result_load = 1'b0;
        wait_cyc(1);
    endtask

    function automatic logic [7:0] hi_of(input logic [12:0] v);
        return {{3{v[12]}}, v[12:8]};
    endfunction

    task automatic narrow_pair(input logic [12:0] v);
        logic [12:0] d, oe;
        load(v);
        read_cycle(1, d, oe);
        chk("R8 low byte", {19'd0, d}, {24'd0, v[7:0]});
        chk("R7 narrow lanes", {19'd0, oe}, 32'h00FF);
        read_cycle(1, d, oe);
        chk("R8 high byte", {19'd0, d}, {24'd0, hi_of(v)});
        chk("R7 narrow lanes", {19'd0, oe}, 32'h00FF);
    endtask

    initial begin
        logic [12:0] d, oe;
        int p0;

        // ---- strap low: latch on release ----
        do_reset(1'b0);
        chk("R5 reset config", {24'd0, cfg_q}, 32'h10);
        chk("R6 idle lanes", {19'd0, bus_oe}, 32'd0);
        chk("R4 no pulse at reset", pulses, 0);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] a, b;
            a = 8'(i * 23 + 5);
            b = a ^ 8'hA7;
            p0 = pulses;
            cfg_write(a, b, 1);
            chk("R2 release-edge data (R1 strap frozen)", {24'd0, cfg_q}, {24'd0, b});
            chk("R4 one pulse per write", pulses - p0, 1);
        end
        p0 = pulses;
        cfg_write(8'h00, 8'h00, 1);
        cfg_write(8'h3C, 8'h3C, 0);
        chk("R4 write without select ignored", {24'd0, cfg_q}, 32'h00);
        chk("R4 pulses", pulses - p0, 1);

        // ---- narrow mode sweep ----
        for (int v = 0; v < 8192; v += 37) narrow_pair(13'(v));
        narrow_pair(13'h1000); narrow_pair(13'h0FFF);
        narrow_pair(13'h1FFF); narrow_pair(13'h0000); narrow_pair(13'h10FF);

        // reads without chip select: no lanes, no advance
        load(13'h1A5C);
        read_cycle(0, d, oe);
        chk("R6 read without select", {19'd0, oe}, 32'd0);
        read_cycle(1, d, oe);
        chk("R8 unselected read did not advance", {19'd0, d}, 32'h5C);
        read_cycle(0, d, oe);
        read_cycle(1, d, oe);
        chk("R8 high byte after unselected read", {19'd0, d}, {24'd0, hi_of(13'h1A5C)});

        // load in mid-pair returns to low byte
        load(13'h0123);
        read_cycle(1, d, oe);
        load(13'h1E77);
        read_cycle(1, d, oe);
        chk("R10 load resets to low byte", {19'd0, d}, 32'h77);

        // ---- wide mode ----
        cfg_write(8'h08, 8'h08, 1);
        chk("R9 wide selected", {24'd0, cfg_q}, 32'h08);
        for (int v = 3; v < 8192; v += 53) begin
            load(13'(v));
            read_cycle(1, d, oe);
            chk("R9 wide data", {19'd0, d}, v);
            chk("R9 wide lanes", {19'd0, oe}, 32'h1FFF);
            read_cycle(1, d, oe);
            chk("R9 wide repeat", {19'd0, d}, v);
        end
        cfg_write(8'h5D, 8'h5D, 1);
        chk("R11 full byte in wide mode", {24'd0, cfg_q}, 32'h5D);

        // wide mode clears a pending high byte
        cfg_write(8'h00, 8'h00, 1);
        load(13'h1234);
        read_cycle(1, d, oe);
        cfg_write(8'h08, 8'h08, 1);
        cfg_write(8'h00, 8'h00, 1);
        read_cycle(1, d, oe);
        chk("R10 wide mode resets to low byte", {19'd0, d}, 32'h34);

        // ---- strap high: latch on assertion ----
        do_reset(1'b1);
        chk("R5 reset config again", {24'd0, cfg_q}, 32'h10);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] a, b;
            a = 8'(i * 29 + 11);
            b = a ^ 8'h5B;
            cfg_write(a, b, 1);
            chk("R3 assert-edge data (R1 strap frozen)", {24'd0, cfg_q}, {24'd0, a});
        end
        cfg_write(8'hC6, 8'h11, 1);
        chk("R11 full byte in narrow mode", {24'd0, cfg_q}, 32'hC6);

        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        finish_up();
    end
endmodule